// File: doc/BRIEF.md
# Multi-Frame SPI Master

This block is a serial peripheral master that sends one to four frames per transfer and gathers the frames returned by the slave. The host writes up to four 32-bit frame slots and a configuration word through a small register port, then issues a start command. The engine drives SCLK, MOSI and an active-low select, and samples MISO. The frame length can be any value from 8 to 16 bits, or 20, 24 or 32 bits. Bit order and frame count can also be set. Frame k sits in the low L bits of slot k, which is bits [32k+L-1 : 32k] of the 128-bit buffer, where L is the frame length.

Both directions are double buffered. When a transfer starts, the engine takes its own copy of the four slots and of the configuration, so the host can write the next transfer while the current one shifts. A start issued while the engine is busy is held as pending and runs right after the current transfer. Received frames collect in a shadow buffer and reach the host-readable buffer only when the transfer ends, which is marked by a one-cycle done pulse. The clock follows mode 0: SCLK idles low, MOSI changes on the falling edge and MISO is captured on the rising edge. A three-wire option keeps the select line inactive.

Register map:
- 0 to 3: write the transmit staging slots, read the received slots.
- 4: configuration, read and write.
- 5: write bit 0 = 1 to start a transfer; read bit 0 = busy, bit 1 = pending.

Top module: `spi_mf_master`

## Requirements
- R1: The configuration field len_code (bits [5:2] of register 4) sets the frame length L. Codes 0 to 8 give L = 8 + code. Code 9 gives 20, code 10 gives 24, and codes 11 to 15 give 32. Each frame produces exactly L SCLK pulses.
- R2: Bit 6 of register 4 selects the bit order. With 0, bit L-1 of the slot is sent first. With 1, bit 0 is sent first. Frame k is taken from bits [L-1:0] of slot k.
- R3: Bits [1:0] of register 4 plus one give the number of frames. Frames go out in slot order 0, 1, 2, 3, back to back, for N*L SCLK pulses in total.
- R4: The MISO value sampled on each rising edge is stored at the same slot and bit position as the bit sent in that clock. Bits of a slot above L, and slots beyond N, read as zero. The received slots are read at addresses 0 to 3.
- R5: The host-readable receive buffer changes only when a transfer completes. A read during a transfer returns the previous result.
- R6: A start sets the pending flag (register 5 bit 1). The staging slots and the configuration are copied when the engine is idle. Writes made after that copy do not affect the running transfer. A transfer still pending when the current one ends starts automatically.
- R7: With bit 7 of register 4 set (three-wire), ss_n stays high for the whole transfer. Otherwise ss_n is low exactly while the engine is busy.
- R8: In four-wire mode, ss_n goes low H system cycles before the first rising SCLK edge. It stays low for H cycles after the last falling edge.
- R9: The SCLK half period is H = div + 1 system cycles, where div is bits [15:8] of register 4. The minimum SCLK period is therefore 2 cycles. SCLK idles low and MOSI changes only while SCLK is low.
- R10: done is high for exactly one cycle. That cycle is the first one with ss_n high again after the transfer, and in it the new received data is already readable.
- R11: After reset, ss_n=1, sclk=0, mosi=0, done=0, the status reads 0 and all received slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach is two transfers chained through the double buffers. The bench has to rewrite the staging slots and the configuration, and issue a second start, while the first transfer is still shifting. It must then read the old receive data before the first done pulse. The stimulus starts a long four-frame 32-bit transfer with a slow divider and polls the busy flag. During that window it loads a different length and bit order for the second transfer, checks the pending flag and reads a received slot. The MOSI stream monitor then shows that the first transfer kept its own slots and settings, and that the second transfer followed right after it with the new ones.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  localparam int unsigned NFRAMES = 4;
  localparam int unsigned SLOT_W  = 32;
  localparam int unsigned DIV_W   = 8;
  localparam int unsigned FR_W    = $clog2(NFRAMES);
  localparam int unsigned BIT_W   = $clog2(SLOT_W);
  localparam int unsigned LEN_W   = BIT_W + 1;
  localparam int unsigned BUF_W   = NFRAMES * SLOT_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } seq_state_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             three_wire;
    logic             lsb_first;
    logic [3:0]       len_code;
    logic [FR_W-1:0]  count_m1;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  // Frame length in bits from the configuration code.
  function automatic logic [LEN_W-1:0] frame_len(input logic [3:0] code);
    if (code <= 4'd8)       frame_len = LEN_W'(8) + LEN_W'(code);
    else if (code == 4'd9)  frame_len = LEN_W'(20);
    else if (code == 4'd10) frame_len = LEN_W'(24);
    else                    frame_len = LEN_W'(32);
  endfunction

endpackage

// File: rtl/spi_mf_tick.sv
module spi_mf_tick #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_mf_seq.sv
module spi_mf_seq
  import spi_mf_pkg::*;
#(
  parameter int unsigned FRW  = 2,
  parameter int unsigned BITW = 5,
  localparam int unsigned LENW = BITW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            tick,
  input  logic [LENW-1:0] len,
  input  logic [FRW-1:0]  last_frame,
  output seq_state_e      state,
  output logic [BITW-1:0] bit_idx,
  output logic [FRW-1:0]  frame_idx,
  output logic            rise,
  output logic            done_set
);

  seq_state_e      state_q, state_d;
  logic [BITW-1:0] bit_q, bit_d;
  logic [FRW-1:0]  frame_q, frame_d;
  logic            bit_end;
  logic            last;

  assign bit_end = ({1'b0, bit_q} == (len - LENW'(1)));
  assign last    = bit_end && (frame_q == last_frame);

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    frame_d  = frame_q;
    rise     = 1'b0;
    done_set = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = ST_LOW;
          bit_d   = '0;
          frame_d = '0;
        end
      end
      ST_LOW: begin
        if (tick) begin
          state_d = ST_HIGH;
          rise    = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          if (last) begin
            state_d = ST_TRAIL;
          end else begin
            state_d = ST_LOW;
            if (bit_end) begin
              bit_d   = '0;
              frame_d = frame_q + 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          state_d  = ST_IDLE;
          done_set = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
    end
  end

  assign state     = state_q;
  assign bit_idx   = bit_q;
  assign frame_idx = frame_q;

endmodule

// File: rtl/spi_mf_master.sv
module spi_mf_master
  import spi_mf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n,
  output logic        busy,
  output logic        done
);

  localparam logic [2:0] ADDR_CFG = 3'(NFRAMES);
  localparam logic [2:0] ADDR_CTL = 3'(NFRAMES + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [SLOT_W-1:0] stage_q [NFRAMES];
  cfg_t              cfg_q;
  cfg_t              act_q;
  logic              pend_q, pend_d;
  logic [BUF_W-1:0]  tx_sh_q;
  logic [BUF_W-1:0]  rx_sh_q;
  logic [BUF_W-1:0]  rx_host_q;
  logic              done_q;

  seq_state_e        state;
  logic [BIT_W-1:0]  bit_idx;
  logic [FR_W-1:0]   frame_idx;
  logic              rise, done_set, tick, load, start, running;
  logic [LEN_W-1:0]  len;
  logic [BIT_W-1:0]  pos;
  logic [FR_W+BIT_W-1:0] bit_addr;

  assign running = (state != ST_IDLE);
  assign load    = (state == ST_IDLE) && pend_q;
  assign start   = wr_en && (wr_addr == ADDR_CTL) && wr_data[0];
  assign len     = frame_len(act_q.len_code);

  // Position inside the slot; length 32 wraps correctly in BIT_W bits.
  assign pos      = act_q.lsb_first ? bit_idx
                                    : (len[BIT_W-1:0] - BIT_W'(1) - bit_idx);
  assign bit_addr = {frame_idx, pos};

  spi_mf_tick #(.DW(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (running),
    .div   (act_q.div),
    .tick  (tick)
  );

  spi_mf_seq #(.FRW(FR_W), .BITW(BIT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (load),
    .tick       (tick),
    .len        (len),
    .last_frame (act_q.count_m1),
    .state      (state),
    .bit_idx    (bit_idx),
    .frame_idx  (frame_idx),
    .rise       (rise),
    .done_set   (done_set)
  );

  // Host register writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NFRAMES; k++) stage_q[k] <= '0;
      cfg_q <= '0;
    end else if (wr_en) begin
      if (wr_addr < ADDR_CFG) stage_q[wr_addr[FR_W-1:0]] <= wr_data;
      if (wr_addr == ADDR_CFG) cfg_q <= wr_data[CFG_W-1:0];
    end
  end

  always_comb begin
    if (start)     pend_d = 1'b1;
    else if (load) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_set;
    end
  end

  // Transmit side: engine copy of the slots and the configuration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      act_q   <= '0;
    end else if (load) begin
      for (int k = 0; k < NFRAMES; k++) tx_sh_q[k*SLOT_W +: SLOT_W] <= stage_q[k];
      act_q <= cfg_q;
    end
  end

  // Receive side: shadow collection, then hand-over at the end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_sh_q <= '0;
    else if (load) rx_sh_q <= '0;
    else if (rise) rx_sh_q[bit_addr] <= miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_host_q <= '0;
    else if (done_set) rx_host_q <= rx_sh_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_CFG)       rd_data = rx_host_q[{rd_addr[FR_W-1:0], {BIT_W{1'b0}}} +: SLOT_W];
    else if (rd_addr == ADDR_CFG) rd_data = {{(32-CFG_W){1'b0}}, cfg_q};
    else if (rd_addr == ADDR_CTL) rd_data = {30'd0, pend_q, running};
  end

  assign sclk = (state == ST_HIGH);
  assign mosi = running && tx_sh_q[bit_addr];
  assign ss_n = !(running && !act_q.three_wire);
  assign busy = running;
  assign done = done_q;

endmodule

// File: rtl/spi_mf_master_chk.sv
module spi_mf_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic ss_n,
  input logic busy,
  input logic done,
  input logic three_act
);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && ss_n && !mosi));

  a_r9_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r7_three_wire_ss: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && three_act) |-> ss_n);

  a_r8_ss_low_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !three_act) |-> !ss_n);

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_follows_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && ss_n));

endmodule

bind spi_mf_master spi_mf_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .ss_n      (ss_n),
  .busy      (busy),
  .done      (done),
  .three_act (act_q.three_wire)
);

// File: tb/spi_mf_master_tb_top.sv
module spi_mf_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        sclk, mosi, miso, ss_n, busy, done;
  logic        inv;

  always #10 clk = ~clk;

  assign miso = mosi ^ inv;

  spi_mf_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .busy(busy), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic         exp_bits [$];
  logic [127:0] exp_rx   [$];
  logic [127:0] last_rx;
  logic [31:0]  stage_w  [4];
  int  exp_h = 1;
  logic exp_three = 1'b0;
  int  mosi_err = 0, tim_err = 0, ss_err = 0;
  int  low_run = 0, high_run = 0;
  logic prev_sclk = 1'b0, prev_busy = 1'b0, mon_b;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected MOSI bits at each rising SCLK and times phases.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !prev_sclk) begin
        if (low_run != exp_h) tim_err++;
        low_run = 0;
        if (exp_bits.size() == 0) mosi_err++;
        else begin
          mon_b = exp_bits.pop_front();
          if (mosi !== mon_b) mosi_err++;
        end
      end
      if (!sclk && prev_sclk) begin
        if (high_run != exp_h) tim_err++;
        high_run = 0;
      end
      if (busy && !prev_busy) low_run = 0;
      if (!busy && prev_busy) begin
        if (low_run != exp_h) tim_err++;
        low_run = 0;
      end
      if (ss_n !== (exp_three ? 1'b1 : !busy)) ss_err++;
      if (sclk) high_run++;
      else if (busy) low_run++;
      prev_sclk = sclk;
      prev_busy = busy;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic int blen(input logic [3:0] c);
    if (c <= 4'd8) return 8 + int'(c);
    if (c == 4'd9) return 20;
    if (c == 4'd10) return 24;
    return 32;
  endfunction

  // Driver: writes slots and configuration, starts, and queues expectations.
  task automatic queue_xfer(input int cnt_m1, input logic [3:0] lcode, input logic lsb,
                            input logic three, input int div);
    int L;
    logic [127:0] erx;
    logic [31:0] mask;
    L = blen(lcode);
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
    erx = '0;
    for (int f = 0; f <= cnt_m1; f++) begin
      for (int i = 0; i < L; i++) exp_bits.push_back(stage_w[f][lsb ? i : L-1-i]);
      erx[32*f +: 32] = (stage_w[f] ^ {32{inv}}) & mask;
    end
    exp_rx.push_back(erx);
    exp_h = div + 1;
    exp_three = three;
    for (int k = 0; k < 4; k++) wr(3'(k), stage_w[k]);
    wr(3'd4, {16'd0, 8'(div), three, lsb, lcode, 2'(cnt_m1)});
    wr(3'd5, 32'd1);
  endtask

  task automatic wait_done(input string tag);
    int k;
    logic [31:0] w;
    logic [127:0] got, expv;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (done !== 1'b1 && k < 20000);
    check(k < 20000, "R10", {tag, " done seen"}, 128'(k), 128'd0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), w);
      got[32*i +: 32] = w;
    end
    expv = exp_rx.pop_front();
    check(got === expv, "R4", {tag, " received slots"}, got, expv);
    check(ss_n === 1'b1, "R10", {tag, " ss_n high at done"}, 128'(ss_n), 128'd1);
    last_rx = expv;
    @(negedge clk);
    check(done === 1'b0, "R10", {tag, " done lasts one cycle"}, 128'(done), 128'd0);
  endtask

  task automatic post_checks(input string tag);
    check(mosi_err == 0, "R2", {tag, " MOSI stream order"}, 128'(mosi_err), 128'd0);
    check(exp_bits.size() == 0, "R3", {tag, " all frame bits sent"}, 128'(exp_bits.size()), 128'd0);
    check(tim_err == 0, "R8", {tag, " select lead/trail and half period (R9)"}, 128'(tim_err), 128'd0);
    check(ss_err == 0, "R7", {tag, " select line level"}, 128'(ss_err), 128'd0);
    mosi_err = 0; tim_err = 0; ss_err = 0;
    exp_bits.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; inv = 1'b0;
    last_rx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check({ss_n, sclk, mosi, done} === 4'b1000, "R11", "pins after reset",
          128'({ss_n, sclk, mosi, done}), 128'b1000);
    rd(3'd5, w);
    check(w === 32'd0, "R11", "status after reset", 128'(w), 128'd0);
    rd(3'd2, w);
    check(w === 32'd0, "R11", "rx slot after reset", 128'(w), 128'd0);

    // R1 R9: one 8-bit frame, MSB first, minimum divide
    stage_w = '{32'h0000_00A5, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333};
    queue_xfer(0, 4'd0, 1'b0, 1'b0, 0);
    wait_done("R1 8-bit min divide");
    post_checks("R1 8-bit min divide");

    // R3: four 32-bit frames, LSB first, inverted return
    inv = 1'b1;
    stage_w = '{32'hDEAD_BEEF, 32'h0123_4567, 32'h8000_0001, 32'hF0F0_3C3C};
    queue_xfer(3, 4'd11, 1'b1, 1'b0, 2);
    wait_done("R3 four 32-bit LSB");
    post_checks("R3 four 32-bit LSB");

    // R1 R2: three 13-bit frames, MSB first
    stage_w = '{32'hFFFF_1ABC, 32'h0000_0F0F, 32'h1234_5555, 32'h9999_9999};
    queue_xfer(2, 4'd5, 1'b0, 1'b0, 1);
    wait_done("R1 13-bit MSB");
    post_checks("R1 13-bit MSB");

    // R1: the wide lengths 20, 24, 16 and a 32 code above 11
    inv = 1'b0;
    for (int c = 0; c < 4; c++) begin
      logic [3:0] codes [4];
      codes = '{4'd9, 4'd10, 4'd8, 4'd15};
      stage_w = '{32'hC3A5_9E17 + 32'(c), 32'h5A5A_0FF1 ^ 32'(c << 3), 32'h7, 32'h8};
      queue_xfer(1, codes[c], 1'(c & 1), 1'b0, 0);
      wait_done("R1 wide length");
      post_checks("R1 wide length");
    end

    // R7: three-wire mode keeps select high
    stage_w = '{32'h0000_0555, 32'h0000_02AA, 32'h0, 32'h0};
    queue_xfer(1, 4'd3, 1'b0, 1'b1, 1);
    wait_done("R7 three-wire");
    post_checks("R7 three-wire");

    // R5 R6: chained transfers through both double buffers
    stage_w = '{32'h1357_9BDF, 32'h2468_ACE0, 32'hFEDC_BA98, 32'h0F1E_2D3C};
    queue_xfer(3, 4'd11, 1'b0, 1'b0, 3);
    do begin
      @(negedge clk);
      rd(3'd5, w);
    end while (w[0] !== 1'b1);
    stage_w = '{32'h0000_ABCD, 32'h0000_1234, 32'h0000_8001, 32'h0000_7FFE};
    queue_xfer(3, 4'd8, 1'b1, 1'b0, 3);
    rd(3'd5, w);
    check(w[1:0] === 2'b11, "R6", "pending while busy", 128'(w[1:0]), 128'b11);
    rd(3'd0, w);
    check(w === last_rx[31:0], "R5", "rx unchanged during transfer", 128'(w), 128'(last_rx[31:0]));
    wait_done("R6 first of chain");
    wait_done("R6 second of chain");
    post_checks("R6 chain");
    rd(3'd5, w);
    check(w === 32'd0, "R6", "idle after chain", 128'(w), 128'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule